// File: doc/BRIEF.md
# Two-Channel Debug Break Sequencer

This block watches the instruction-fetch stream and, for its second channel, the data bus. It raises a break request toward the core when a programmed condition is met. Channel A matches a fetch address. Channel B matches a fetch address and can also require a data value on the data bus in the same cycle. Software programs the compare values and a control word through a small register port. The control word chooses three things:

- for each channel, whether the break is taken before the matched instruction runs or after it retires;
- whether channel B also needs the data match;
- whether the two channels act on their own or as an ordered pair.

In ordered (sequential) mode, a channel A hit does not stop the core. It only records that A has happened. A later channel B hit then sets B's flag and requests the break. Each channel keeps a sticky hit flag, and software clears it by writing a zero to it. A before-execution break is requested combinationally in the cycle the matching fetch is presented. An after-execution break is held pending and requested in the cycle of the next instruction-retire strobe.

Top module: `brk_seq_ctl`

## Requirements
- R1: Control bit 10 sets channel A timing. With 0, break_req is high in the same cycle as a fetch whose address equals the channel A value. With 1, break_req stays low in that cycle and in following cycles, and goes high in the cycle of the next retire strobe.
- R2: Control bit 6 sets channel B timing with the same encoding and behaviour as R1.
- R3: With control bit 7 at 0, channel B ignores the data bus. With bit 7 at 1, channel B also needs data_valid high and data_bus equal to the channel B data value in the fetch cycle. Without that data match, no flag is set and no break is requested.
- R4: With control bit 3 at 0, each channel sets its own flag and requests its own break. With bit 3 at 1, a channel A hit sets flag A and arms the pair but requests no break. A channel B hit in a later cycle while armed sets flag B, requests the break and disarms the pair.
- R5: In sequential mode, a channel B hit while not armed sets no flag and requests no break.
- R6: Control bits other than 10, 7, 6 and 3 always read 0, and writing 1 to them has no effect.
- R7: After reset, the control word, both flags and break_req are 0.
- R8: The status register at address 1 holds flag A in bit 0 and flag B in bit 1. The flags are sticky. Writing 0 to a bit clears it and writing 1 leaves it. Clearing flag A also disarms the sequential pair.
- R9: The register map is: address 0 control, 2 channel A address, 3 channel B address, 4 channel B data. Reads are combinational, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | RW | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_valid | input | 1 | Instruction fetch presented this cycle |
| fetch_pc | input | AW | Fetch address |
| data_valid | input | 1 | Data bus value valid this cycle |
| data_bus | input | DW | Data bus value |
| retire | input | 1 | Instruction-retire strobe |
| break_req | output | 1 | Break request to the core |
| flag_a | output | 1 | Channel A sticky hit flag |
| flag_b | output | 1 | Channel B sticky hit flag |

## Verification
The assertions assume four things about the inputs:
- a retire strobe always belongs to the oldest fetch still in flight, so an after-execution break is released by the first retire that follows the match;
- the data value for channel B arrives in the same cycle as its fetch;
- the control word is not rewritten while a break is pending;
- the two channel addresses differ.

The stimulus keeps within these assumptions. It issues a retire strobe only after a matching fetch has been presented, and it programs distinct addresses for the two channels. It changes the control word only with no break pending, and always presents data alongside the fetch it qualifies.

// File: rtl/brk_seq_ctl.sv
module brk_seq_ctl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          data_valid,
  input  logic [DW-1:0] data_bus,
  input  logic          retire,
  output logic          break_req,
  output logic          flag_a,
  output logic          flag_b
);
  localparam int BIT_TIM_A = 10;
  localparam int BIT_DAT_B = 7;
  localparam int BIT_TIM_B = 6;
  localparam int BIT_SEQ   = 3;
  localparam logic [31:0] CTL_MASK = (32'd1 << BIT_TIM_A) | (32'd1 << BIT_DAT_B)
                                   | (32'd1 << BIT_TIM_B) | (32'd1 << BIT_SEQ);
  localparam logic [RW-1:0] A_CTL = RW'(0);
  localparam logic [RW-1:0] A_STA = RW'(1);
  localparam logic [RW-1:0] A_PCA = RW'(2);
  localparam logic [RW-1:0] A_PCB = RW'(3);
  localparam logic [RW-1:0] A_DTB = RW'(4);

  logic [31:0]   ctl_q;
  logic [AW-1:0] pc_a_q, pc_b_q;
  logic [DW-1:0] dat_b_q;
  logic          flag_a_q, flag_b_q, armed_q, pend_a_q, pend_b_q;

  wire tim_a = ctl_q[BIT_TIM_A];
  wire tim_b = ctl_q[BIT_TIM_B];
  wire dat_en = ctl_q[BIT_DAT_B];
  wire seq   = ctl_q[BIT_SEQ];

  wire hit_a = fetch_valid && (fetch_pc == pc_a_q);
  wire hit_b = fetch_valid && (fetch_pc == pc_b_q)
               && (!dat_en || (data_valid && data_bus == dat_b_q));
  wire ev_a  = hit_a;
  wire ev_b  = hit_b && (!seq || armed_q);
  wire brk_a = ev_a && !seq;

  wire sta_we  = reg_we && reg_addr == A_STA;
  wire clr_a   = sta_we && !reg_wdata[0];
  wire clr_b   = sta_we && !reg_wdata[1];

  assign break_req = (brk_a && !tim_a) || (ev_b && !tim_b)
                   || (retire && (pend_a_q || pend_b_q));
  assign flag_a = flag_a_q;
  assign flag_b = flag_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      pc_a_q  <= '0;
      pc_b_q  <= '0;
      dat_b_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTL: ctl_q   <= reg_wdata & CTL_MASK;
        A_PCA: pc_a_q  <= AW'(reg_wdata);
        A_PCB: pc_b_q  <= AW'(reg_wdata);
        A_DTB: dat_b_q <= DW'(reg_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a_q <= 1'b0;
      flag_b_q <= 1'b0;
      armed_q  <= 1'b0;
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
    end else begin
      flag_a_q <= (flag_a_q && !clr_a) || ev_a;
      flag_b_q <= (flag_b_q && !clr_b) || ev_b;
      armed_q  <= (seq && ev_a) || (armed_q && !ev_b && !clr_a);
      pend_a_q <= (pend_a_q && !retire) || (brk_a && tim_a);
      pend_b_q <= (pend_b_q && !retire) || (ev_b && tim_b);
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = ctl_q;
      A_STA:   reg_rdata = {30'd0, flag_b_q, flag_a_q};
      A_PCA:   reg_rdata = 32'(pc_a_q);
      A_PCB:   reg_rdata = 32'(pc_b_q);
      A_DTB:   reg_rdata = 32'(dat_b_q);
      default: reg_rdata = '0;
    endcase
  end

  AST_BEFORE_A_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_pc == pc_a_q && !ctl_q[BIT_TIM_A] && !ctl_q[BIT_SEQ]) |-> break_req); // R1
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a_q && !retire) |=> pend_a_q); // R1
  AST_SEQ_B_AFTER_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_b_q) && $past(ctl_q[BIT_SEQ])) |-> $past(flag_a_q)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTL) |-> ((reg_rdata & ~CTL_MASK) == 32'd0)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a_q && !(reg_we && reg_addr == A_STA && !reg_wdata[0])) |=> flag_a_q); // R8
endmodule

// File: tb/brk_seq_ctl_tb.sv
module brk_seq_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic fetch_valid = 1'b0, data_valid = 1'b0, retire = 1'b0;
  logic [31:0] fetch_pc = '0, data_bus = '0;
  logic break_req, flag_a, flag_b;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  brk_seq_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .data_valid(data_valid), .data_bus(data_bus),
    .retire(retire), .break_req(break_req), .flag_a(flag_a), .flag_b(flag_b));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic fetch(logic [31:0] pc, logic dv, logic [31:0] db, string req, logic exp_brk);
    @(negedge clk); fetch_pc = pc; fetch_valid = 1'b1; data_valid = dv; data_bus = db;
    #1 chk(req, 32'(break_req), 32'(exp_brk));
    @(negedge clk); fetch_valid = 1'b0; data_valid = 1'b0;
  endtask

  task automatic ret(string req, logic exp_brk);
    @(negedge clk); retire = 1'b1;
    #1 chk(req, 32'(break_req), 32'(exp_brk));
    @(negedge clk); retire = 1'b0;
  endtask

  task automatic idle(string req);
    @(negedge clk); #1 chk(req, 32'(break_req), 32'd0);
  endtask

  task automatic status(string req, logic [31:0] exp);
    logic [31:0] v;
    rd(3'd1, v); chk(req, v, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R7 ctl", v, 0);
    status("R7 status", 0);
    chk("R7 break", 32'(break_req), 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd2, 32'h100); wr(3'd3, 32'h200); wr(3'd4, 32'hAA);
    rd(3'd2, v); chk("R9 pcA", v, 32'h100);
    rd(3'd3, v); chk("R9 pcB", v, 32'h200);
    rd(3'd4, v); chk("R9 dataB", v, 32'hAA);
    rd(3'd6, v); chk("R9 unmapped", v, 0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R6 reserved", v, 32'h4C8);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_before();
    fetch(32'h100, 0, 0, "R1 before A", 1);
    status("R8 flag A set", 32'h1);
    fetch(32'h104, 0, 0, "R1 no hit", 0);
    wr(3'd1, 32'h3); status("R8 write one keeps", 32'h1);
    wr(3'd1, 32'h0); status("R8 write zero clears", 32'h0);
    fetch(32'h200, 0, 0, "R2 before B", 1);
    status("R4 indep flag B", 32'h2);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_after();
    wr(3'd0, 32'h400);
    fetch(32'h100, 0, 0, "R1 after A not at fetch", 0);
    idle("R1 after A waits");
    ret("R1 after A at retire", 1);
    ret("R1 after A released once", 0);
    wr(3'd0, 32'h40);
    fetch(32'h200, 0, 0, "R2 after B not at fetch", 0);
    ret("R2 after B at retire", 1);
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
  endtask

  task automatic t_data();
    wr(3'd0, 32'h80);
    fetch(32'h200, 1, 32'h55, "R3 data mismatch", 0);
    fetch(32'h200, 0, 32'hAA, "R3 data not valid", 0);
    status("R3 no flag", 32'h0);
    fetch(32'h200, 1, 32'hAA, "R3 data match", 1);
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    fetch(32'h200, 1, 32'h55, "R3 data ignored", 1);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_seq();
    wr(3'd0, 32'h8);
    fetch(32'h200, 0, 0, "R5 B before A", 0);
    status("R5 no flag", 32'h0);
    fetch(32'h100, 0, 0, "R4 A arms no break", 0);
    status("R4 flag A", 32'h1);
    fetch(32'h200, 0, 0, "R4 B after A", 1);
    status("R4 flags", 32'h3);
    wr(3'd1, 32'h1);
    fetch(32'h200, 0, 0, "R4 disarmed after B", 0);
    status("R4 B not reset", 32'h1);
    wr(3'd1, 32'h0);
    fetch(32'h100, 0, 0, "R8 rearm", 0);
    wr(3'd1, 32'h0);
    fetch(32'h200, 0, 0, "R8 clear disarms", 0);
    wr(3'd0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1 t_reset();
    #20 rst_n = 1'b1;
    t_regs();
    t_before();
    t_after();
    t_data();
    t_seq();
    finish_run();
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule